// File: doc/BRIEF.md
# UART Receive Holding Queue with Break Insertion

This block sits between a UART receiver and the host read path. It stores received bytes in a small first-in first-out queue of four entries. The host reads them back oldest first. A line break seen by the receiver is stored as a zero byte and raises a sticky break-change flag.

The block reports two status flags to the host: one says that data is waiting, the other says the queue is full. It also tells the receiver whether it may hand over another byte. A reset of the receiver drives a synchronous flush that empties the queue.

A break is never lost. When the queue is already full, the zero byte replaces the newest stored byte. A host read of an empty queue returns zero and leaves all state unchanged. All inputs are sampled on the rising clock edge. The read data output shows the oldest byte combinationally, and a read request removes that byte at the edge.

Top module: `rxq_hold_fifo`

## Requirements
- R1: The queue holds up to four bytes. `rd_data` shows the oldest stored byte while the queue is not empty, and a `rd_req` pulse removes that byte at the clock edge, so bytes come out in arrival order.
- R2: `data_ready` is high in the cycle after any push. It goes low only after a pop or flush leaves the queue empty.
- R3: `queue_full` is high exactly when four bytes are stored. A pop clears it unless a break is stored in the same cycle.
- R4: When the queue is empty, `rd_data` is 0x00, and a `rd_req` pulse changes no flag and no stored byte.
- R5: A `brk_evt` pulse stores a 0x00 byte even when `rx_enable` is low. It sets `brk_flag` in the next cycle. When `brk_evt` and `wr_valid` arrive in the same cycle, the break is stored and the data byte is dropped.
- R6: A break that arrives while four bytes are stored and no pop happens in that cycle replaces the fourth (newest) byte with 0x00, and the count stays at four. If a pop happens in the same cycle, the zero byte is appended instead.
- R7: `can_accept` equals `rx_enable` AND NOT `queue_full`. A `wr_valid` pulse while `can_accept` is low stores nothing.
- R8: `flush` empties the queue, and `data_ready` and `queue_full` are low in the next cycle. Flush takes priority over everything else: a read or data push in the same cycle has no effect, and a break byte in the same cycle is discarded, although `brk_flag` is still set.
- R9: A push and a pop in the same cycle both take effect. The count stays the same and the flags follow the resulting count.
- R10: `brk_flag` stays set until a `brk_clr` pulse arrives. When `brk_evt` and `brk_clr` arrive in the same cycle, the flag is set.
- R11: After reset the queue is empty and `data_ready`, `queue_full` and `brk_flag` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enabled |
| flush | input | 1 | Synchronous flush from receiver reset |
| wr_valid | input | 1 | Receiver offers a data byte |
| wr_data | input | 8 | Received data byte |
| brk_evt | input | 1 | Break detected on the line |
| brk_clr | input | 1 | Clear pulse for the break-change flag |
| rd_req | input | 1 | Host read pulse, removes the oldest byte |
| rd_data | output | 8 | Oldest stored byte, or 0x00 when empty |
| data_ready | output | 1 | At least one byte stored |
| queue_full | output | 1 | Four bytes stored |
| brk_flag | output | 1 | Sticky break-change flag |
| can_accept | output | 1 | Receiver may deliver a byte |

## Verification
The assertions assume that every control input is a level sampled once per rising edge. They also assume that the receiver only counts a byte as delivered when `can_accept` was high. Both assumptions mean that a push attempted while the queue is full is treated as dropped, not as lost data. The stimulus changes inputs one time unit after the edge and holds them for exactly one cycle. It mirrors the queue in a reference model, so pulses that combine break, read, flush and clear in the same cycle stay within these rules while still reaching the corner cases.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    // Kind of write applied to the storage in one cycle.
    typedef enum logic [1:0] {
        WR_NONE    = 2'd0,
        WR_APPEND  = 2'd1,
        WR_REPLACE = 2'd2
    } wr_kind_e;
endpackage

// File: rtl/rxq_push_ctl.sv
module rxq_push_ctl
    import rxq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_enable,
    input  logic         flush,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    input  logic         brk_evt,
    input  logic         full,
    input  logic         pop_go,
    output wr_kind_e     wr_kind,
    output logic [W-1:0] wr_byte,
    output logic         can_accept
);
    always_comb begin
        can_accept = rx_enable && !full;
        wr_kind    = WR_NONE;
        wr_byte    = '0;
        if (flush) begin
            wr_kind = WR_NONE;
        end else if (brk_evt) begin
            wr_kind = (full && !pop_go) ? WR_REPLACE : WR_APPEND;
            wr_byte = '0;
        end else if (wr_valid && can_accept) begin
            wr_kind = WR_APPEND;
            wr_byte = wr_data;
        end
    end

    // R6
    brk_always_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_evt && !flush) |-> (wr_kind != WR_NONE));

    // R7
    no_push_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk_evt && !can_accept) |-> (wr_kind == WR_NONE));
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          rd_req,
    input  wr_kind_e      wr_kind,
    input  logic [W-1:0]  wr_byte,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          pop_go
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wptr;
        logic [PW-1:0]           rptr;
        logic [CW-1:0]           cnt;
    } store_t;

    store_t st_d, st_q;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    function automatic logic [PW-1:0] ptr_prev(input logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - PW'(1);
    endfunction

    always_comb begin
        st_d   = st_q;
        pop_go = rd_req && !flush && (st_q.cnt != '0);
        if (flush) begin
            st_d.cnt  = '0;
            st_d.wptr = '0;
            st_d.rptr = '0;
        end else begin
            if (pop_go) begin
                st_d.rptr = ptr_next(st_q.rptr);
            end
            unique case (wr_kind)
                WR_APPEND: begin
                    st_d.mem[st_q.wptr] = wr_byte;
                    st_d.wptr           = ptr_next(st_q.wptr);
                end
                WR_REPLACE: begin
                    st_d.mem[ptr_prev(st_q.wptr)] = wr_byte;
                end
                default: ;
            endcase
            unique case ({wr_kind == WR_APPEND, pop_go})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = (st_q.cnt != '0) ? st_q.mem[st_q.rptr] : '0;
    assign count = st_q.cnt;

    // R1
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R4
    empty_read_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !flush && st_q.cnt == '0 && wr_kind == WR_NONE)
        |=> (st_q.cnt == '0) && $stable(st_q.rptr) && $stable(st_q.mem));

    // R9
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_go && wr_kind == WR_APPEND) |=> $stable(st_q.cnt));
endmodule

// File: rtl/rxq_hold_fifo.sv
module rxq_hold_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_enable,
    input  logic         flush,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    input  logic         brk_evt,
    input  logic         brk_clr,
    input  logic         rd_req,
    output logic [W-1:0] rd_data,
    output logic         data_ready,
    output logic         queue_full,
    output logic         brk_flag,
    output logic         can_accept
);
    localparam int CW = $clog2(DEPTH + 1);

    wr_kind_e      wr_kind;
    logic [W-1:0]  wr_byte;
    logic [CW-1:0] count;
    logic          pop_go;
    logic          brk_d, brk_q;

    assign data_ready = (count != '0);
    assign queue_full = (count == CW'(DEPTH));

    rxq_push_ctl #(.W(W)) push_ctl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_enable  (rx_enable),
        .flush      (flush),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .brk_evt    (brk_evt),
        .full       (queue_full),
        .pop_go     (pop_go),
        .wr_kind    (wr_kind),
        .wr_byte    (wr_byte),
        .can_accept (can_accept)
    );

    rxq_store #(.DEPTH(DEPTH), .W(W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .rd_req  (rd_req),
        .wr_kind (wr_kind),
        .wr_byte (wr_byte),
        .head    (rd_data),
        .count   (count),
        .pop_go  (pop_go)
    );

    always_comb begin
        brk_d = brk_q;
        if (brk_evt) begin
            brk_d = 1'b1;
        end else if (brk_clr) begin
            brk_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_q <= 1'b0;
        end else begin
            brk_q <= brk_d;
        end
    end

    assign brk_flag = brk_q;

    // R7
    full_blocks_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        queue_full |-> !can_accept);

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!data_ready && !queue_full));

    // R5
    brk_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_evt && !flush) |=> data_ready);

    // R10
    brk_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> brk_flag);

    // R10
    brk_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag && !brk_clr) |=> brk_flag);
endmodule

// File: tb/rxq_hold_fifo_tb.sv
module rxq_hold_fifo_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_enable = 1'b0, flush = 1'b0, wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       brk_evt = 1'b0, brk_clr = 1'b0, rd_req = 1'b0;
    logic [7:0] rd_data;
    logic       data_ready, queue_full, brk_flag, can_accept;

    int checks = 0;
    int failures = 0;

    // Reference model: expected queue contents and break flag.
    logic [7:0] exp_q[$];
    logic       exp_brk = 1'b0;

    always #2.5 clk = ~clk;

    rxq_hold_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .flush(flush),
        .wr_valid(wr_valid), .wr_data(wr_data), .brk_evt(brk_evt),
        .brk_clr(brk_clr), .rd_req(rd_req), .rd_data(rd_data),
        .data_ready(data_ready), .queue_full(queue_full),
        .brk_flag(brk_flag), .can_accept(can_accept)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Driver and monitor for one cycle: applies the pulses, compares the
    // popped byte against the scoreboard, updates the model, checks flags.
    task automatic cycle(input string tag, input logic wv, input logic [7:0] wd,
                         input logic brk, input logic rd, input logic fl,
                         input logic clr);
        int  sz;
        bit  pop;
        wr_valid = wv; wr_data = wd; brk_evt = brk; rd_req = rd;
        flush = fl; brk_clr = clr;
        #1;
        sz = exp_q.size();
        check({tag, " can_accept R7"}, {7'd0, can_accept},
              {7'd0, rx_enable && (sz != 4)});
        if (rd) check({tag, " rd_data R1/R4"}, rd_data, (sz > 0) ? exp_q[0] : 8'h00);
        pop = rd && (sz > 0) && !fl;
        if (fl) begin
            exp_q.delete();
        end else begin
            if (pop) void'(exp_q.pop_front());
            if (brk) begin
                if (exp_q.size() == 4) exp_q[3] = 8'h00;
                else exp_q.push_back(8'h00);
            end else if (wv && rx_enable && sz != 4) begin
                exp_q.push_back(wd);
            end
        end
        if (brk) exp_brk = 1'b1;
        else if (clr) exp_brk = 1'b0;
        @(posedge clk); #1;
        wr_valid = 0; brk_evt = 0; rd_req = 0; flush = 0; brk_clr = 0;
        check({tag, " data_ready R2"}, {7'd0, data_ready}, {7'd0, exp_q.size() > 0});
        check({tag, " queue_full R3"}, {7'd0, queue_full}, {7'd0, exp_q.size() == 4});
        check({tag, " brk_flag R10"}, {7'd0, brk_flag}, {7'd0, exp_brk});
    endtask

    task automatic push(input string tag, input logic [7:0] b);
        cycle(tag, 1, b, 0, 0, 0, 0);
    endtask

    task automatic pop(input string tag);
        cycle(tag, 0, 8'h00, 0, 1, 0, 0);
    endtask

    task automatic drain(input string tag);
        while (exp_q.size() > 0) pop(tag);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        check("R11 ready", {7'd0, data_ready}, 8'd0);
        check("R11 full", {7'd0, queue_full}, 8'd0);
        check("R11 brk", {7'd0, brk_flag}, 8'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R11 rd_data", rd_data, 8'h00);

        // R7: disabled receiver ignores data
        push("R7 disabled", 8'h5A);
        rx_enable = 1'b1;

        // R1/R2: order of three bytes
        push("R1", 8'hA1); push("R1", 8'hB2); push("R1", 8'hC3);
        drain("R1");

        // R4: read of empty queue, then state still usable
        pop("R4 empty");
        pop("R4 empty again");
        push("R4 after", 8'h77);
        drain("R4 after");

        // R3/R7: fill, dropped push when full
        push("R3", 8'h11); push("R3", 8'h22); push("R3", 8'h33); push("R3", 8'h44);
        push("R7 full", 8'hEE);
        // R6: break overwrites newest when full
        cycle("R6 overwrite", 0, 8'h00, 1, 0, 0, 0);
        cycle("R10 clear", 0, 8'h00, 0, 0, 0, 1);
        // R6: break with pop appends
        cycle("R6 with pop", 0, 8'h00, 1, 1, 0, 0);
        drain("R6 drain");

        // R9: push and pop same cycle at count two
        push("R9", 8'h01); push("R9", 8'h02);
        cycle("R9 both", 1, 8'h03, 0, 1, 0, 0);
        drain("R9 drain");

        // R5: break while disabled, break beats data
        rx_enable = 1'b0;
        cycle("R5 disabled brk", 0, 8'h00, 1, 0, 0, 1);
        rx_enable = 1'b1;
        cycle("R5 brk beats data", 1, 8'hCC, 1, 0, 0, 0);
        drain("R5 drain");

        // R10: clear, then set and clear together
        cycle("R10 clr", 0, 8'h00, 0, 0, 0, 1);
        cycle("R10 idle", 0, 8'h00, 0, 0, 0, 0);
        cycle("R10 both", 0, 8'h00, 1, 0, 0, 1);
        drain("R10 drain");

        // R8: flush with data, flush with break and read
        push("R8", 8'h9A); push("R8", 8'h9B); push("R8", 8'h9C); push("R8", 8'h9D);
        cycle("R8 flush", 0, 8'h00, 0, 1, 1, 0);
        cycle("R8 clr", 0, 8'h00, 0, 0, 0, 1);
        push("R8", 8'h42);
        cycle("R8 flush brk", 1, 8'h55, 1, 1, 1, 0);
        pop("R8 after flush");
        push("R8 reuse", 8'h66);
        drain("R8 reuse");

        finish_run();
    end
endmodule